// File: doc/BRIEF.md
# Receive FIFO Flow-Control Controller with RTS Hysteresis

This block pairs a 64-entry receive FIFO with the logic that drives an active-low request-to-send output (`rts_n`). Each FIFO entry holds one received byte and three error tags. The controller compares the FIFO fill level with three levels. The trigger level raises a receive-data interrupt. The upper limit drives `rts_n` high, which asks the remote transmitter to pause. The lower limit drives `rts_n` low again, which lets the remote transmitter resume. Because the upper and lower limits are separate from each other and from the trigger, the interrupt and the flow-control action are decoupled. The gap between the two limits gives the output hysteresis.

The limits come from one of two sources. In fixed-table mode, a 2-bit selector picks a trigger from a small table. The upper limit is the next higher table entry and the lower limit is the next lower entry. In programmable mode, the upper limit is the trigger plus a hysteresis value and the lower limit is the trigger minus that value, each clamped to the FIFO range. Automatic control acts only while it is enabled and software requests RTS. At all other times the pin mirrors the software request. A latched interrupt flag records each low-to-high change of `rts_n`.

Top module: `rx_rts_flow_ctrl`

## Requirements
- R1: After synchronous reset, `rts_n` is 1, `fill_level` is 0, and both `rts_irq` and `rx_trig_irq` are 0 with a nonzero trigger.
- R2: When `auto_rts_en` is 0, or `sw_rts` is 0, `rts_n` equals the inverse of `sw_rts` one clock later.
- R3: The FIFO keeps up to 64 entries in arrival order. Each entry carries `wr_data[7:0]` and the tags `wr_brk`, `wr_frm` and `wr_par`. The head entry is shown on the `rd_*` outputs before it is popped, and `fill_level` changes on the clock edge that accepts a push or a pop.
- R4: A push while 64 entries are held is dropped and does not change the FIFO. A pop while the FIFO is empty is ignored.
- R5: `rx_trig_irq` is 1 exactly while `fill_level` is at least the active trigger level. It has no effect on `rts_n`.
- R6: In programmable mode (`tbl_mode`=0), the trigger is min(`prog_trig`,64), the upper limit is min(trigger+`prog_hyst`,64) and the lower limit is max(trigger−`prog_hyst`,0). While automatic control is active, `rts_n` goes to 1 one clock after `fill_level` reaches the upper limit.
- R7: While automatic control is active, `rts_n` goes to 0 one clock after `fill_level` falls to the lower limit or below. It holds its value while the level lies strictly between the two limits. When the level is at or above the upper limit, the pause takes priority.
- R8: In table mode (`tbl_mode`=1), `tbl_sel` values 0 to 3 pick the trigger 8, 16, 32 or 56. The upper limit is the next higher entry, or 64 above 56. The lower limit is the next lower entry, or 0 below 8.
- R9: When `rts_irq_en` is 1 in the cycle that `rts_n` changes from 0 to 1, `rts_irq` becomes 1 on that same clock edge. When `rts_irq_en` is 0, the change sets nothing.
- R10: `rts_irq` stays set until `rts_irq_clr` is 1 at a clock edge. If a new rising change of `rts_n` happens at the same edge as the clear, the flag stays set.
- R11: After `rts_n` goes high, the FIFO keeps accepting pushes until it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one received entry |
| wr_data | input | 8 | Received byte |
| wr_brk | input | 1 | Break tag of the received byte |
| wr_frm | input | 1 | Framing-error tag |
| wr_par | input | 1 | Parity-error tag |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry byte |
| rd_brk | output | 1 | Head entry break tag |
| rd_frm | output | 1 | Head entry framing tag |
| rd_par | output | 1 | Head entry parity tag |
| fill_level | output | 7 | Number of entries held (0 to 64) |
| tbl_mode | input | 1 | 1: fixed table limits, 0: programmable limits |
| tbl_sel | input | 2 | Table entry selector |
| prog_trig | input | 7 | Programmable trigger level |
| prog_hyst | input | 7 | Programmable hysteresis distance |
| auto_rts_en | input | 1 | Enable automatic RTS control |
| rts_irq_en | input | 1 | Enable the RTS-change interrupt |
| sw_rts | input | 1 | Software RTS request (1 asserts, driving `rts_n` low) |
| rts_irq_clr | input | 1 | Synchronous clear of the RTS interrupt flag |
| rts_n | output | 1 | Active-low request-to-send |
| rx_trig_irq | output | 1 | Receive trigger interrupt |
| rts_irq | output | 1 | Latched RTS-change interrupt flag |

## Verification
The bench builds the block with its default 64-entry depth and 8-bit data. At that size each configuration can be swept through every fill level from 0 to 64 and back down to 0. The sweep covers all four table selections and several programmable trigger and hysteresis pairs, including limits clamped at 0 and at 64 and a case where both limits are zero. This makes every threshold crossing, the hold band, the overflow and underflow boundaries, and the order of data and tags directly observable at the pins. In manual mode `rts_n` can be toggled on a chosen clock edge, which lets the bench line up an interrupt clear with a new rising change of `rts_n`.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    localparam int unsigned FIFO_DEPTH = 64;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int unsigned TBL_N      = 4;
    localparam int unsigned SEL_W      = $clog2(TBL_N);

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t DEPTH_LVL = lvl_t'(FIFO_DEPTH);

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        lvl_t trig;
        lvl_t upper;
        lvl_t lower;
    } thresh_t;

    // Fixed trigger table; indices outside the table saturate to empty or full.
    function automatic lvl_t tbl_level(input int idx);
        lvl_t v;
        case (idx)
            0:       v = lvl_t'(8);
            1:       v = lvl_t'(16);
            2:       v = lvl_t'(32);
            3:       v = lvl_t'(56);
            default: v = (idx < 0) ? '0 : DEPTH_LVL;
        endcase
        return v;
    endfunction

    function automatic lvl_t clamp_depth(input logic [LVL_W:0] v);
        return (v > {1'b0, DEPTH_LVL}) ? DEPTH_LVL : v[LVL_W-1:0];
    endfunction

    function automatic lvl_t floor_sub(input lvl_t a, input lvl_t b);
        return (b >= a) ? '0 : lvl_t'(a - b);
    endfunction

endpackage

// File: rtl/rxfc_fifo.sv
module rxfc_fifo
    import rxfc_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head_entry,
    output lvl_t      level
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam lvl_t FULL_LVL = lvl_t'(DEPTH);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    lvl_t             count;
    logic             push_ok;
    logic             pop_ok;

    assign push_ok    = push && (count != FULL_LVL);
    assign pop_ok     = pop && (count != '0);
    assign head_entry = mem[rd_ptr];
    assign level      = count;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && level == FULL_LVL) |=> (level == FULL_LVL)); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && level == '0) |=> (level == '0)); // R4

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL); // R3

endmodule

// File: rtl/rxfc_thresh.sv
module rxfc_thresh
    import rxfc_pkg::*;
(
    input  logic             tbl_mode,
    input  logic [SEL_W-1:0] tbl_sel,
    input  lvl_t             prog_trig,
    input  lvl_t             prog_hyst,
    output thresh_t          thr
);
    lvl_t             trig_c;
    logic [LVL_W:0]   up_sum;
    thresh_t          thr_tbl;
    thresh_t          thr_prog;

    always_comb begin
        trig_c = (prog_trig > DEPTH_LVL) ? DEPTH_LVL : prog_trig;
        up_sum = {1'b0, trig_c} + {1'b0, prog_hyst};

        thr_prog.trig  = trig_c;
        thr_prog.upper = clamp_depth(up_sum);
        thr_prog.lower = floor_sub(trig_c, prog_hyst);

        thr_tbl.trig  = tbl_level(int'(tbl_sel));
        thr_tbl.upper = tbl_level(int'(tbl_sel) + 1);
        thr_tbl.lower = tbl_level(int'(tbl_sel) - 1);

        thr = tbl_mode ? thr_tbl : thr_prog;
    end

    AST_LIMITS_IN_RANGE: assert property (@(posedge tbl_mode)
        (thr.upper <= DEPTH_LVL) && (thr.lower <= DEPTH_LVL)); // R6

endmodule

// File: rtl/rxfc_rts_ctrl.sv
module rxfc_rts_ctrl
    import rxfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lvl_t    level,
    input  thresh_t thr,
    input  logic    auto_rts_en,
    input  logic    sw_rts,
    input  logic    rts_irq_en,
    input  logic    rts_irq_clr,
    output logic    rts_n,
    output logic    rx_trig_irq,
    output logic    rts_irq
);
    logic auto_act;
    logic paused_q, paused_d;
    logic rts_n_q, rts_n_d;
    logic irq_q, irq_d;
    logic rise;

    always_comb begin
        auto_act = auto_rts_en && sw_rts;
        paused_d = paused_q;
        if (!auto_act) begin
            paused_d = 1'b0;
        end else if (level >= thr.upper) begin
            paused_d = 1'b1;
        end else if (level <= thr.lower) begin
            paused_d = 1'b0;
        end
        rts_n_d = auto_act ? paused_d : !sw_rts;
        rise    = rts_n_d && !rts_n_q;
        irq_d   = (rise && rts_irq_en) || (irq_q && !rts_irq_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            paused_q <= 1'b0;
            rts_n_q  <= 1'b1;
            irq_q    <= 1'b0;
        end else begin
            paused_q <= paused_d;
            rts_n_q  <= rts_n_d;
            irq_q    <= irq_d;
        end
    end

    assign rts_n       = rts_n_q;
    assign rts_irq     = irq_q;
    assign rx_trig_irq = (level >= thr.trig);

    AST_RTS_OFF_AT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && sw_rts && level >= thr.upper) |=> rts_n); // R6

    AST_RTS_ON_AT_LOWER: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && sw_rts && level <= thr.lower && level < thr.upper) |=> !rts_n); // R7

    AST_MANUAL_PIN: assert property (@(posedge clk) disable iff (rst)
        !(auto_rts_en && sw_rts) |=> (rts_n == !$past(sw_rts))); // R2

    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(rts_n) && $past(rts_irq_en)) |-> rts_irq); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rts_irq && !rts_irq_clr) |=> rts_irq); // R10

endmodule

// File: rtl/rx_rts_flow_ctrl.sv
module rx_rts_flow_ctrl
    import rxfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic             wr_brk,
    input  logic             wr_frm,
    input  logic             wr_par,
    input  logic             rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic             rd_brk,
    output logic             rd_frm,
    output logic             rd_par,
    output logic [LVL_W-1:0] fill_level,
    input  logic             tbl_mode,
    input  logic [SEL_W-1:0] tbl_sel,
    input  logic [LVL_W-1:0] prog_trig,
    input  logic [LVL_W-1:0] prog_hyst,
    input  logic             auto_rts_en,
    input  logic             rts_irq_en,
    input  logic             sw_rts,
    input  logic             rts_irq_clr,
    output logic             rts_n,
    output logic             rx_trig_irq,
    output logic             rts_irq
);
    rx_entry_t in_entry;
    rx_entry_t head;
    lvl_t      level;
    thresh_t   thr;

    always_comb begin
        in_entry.brk  = wr_brk;
        in_entry.frm  = wr_frm;
        in_entry.par  = wr_par;
        in_entry.data = wr_data;
    end

    rxfc_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .push       (wr_en),
        .push_entry (in_entry),
        .pop        (rd_en),
        .head_entry (head),
        .level      (level)
    );

    rxfc_thresh thresh_i (
        .tbl_mode  (tbl_mode),
        .tbl_sel   (tbl_sel),
        .prog_trig (prog_trig),
        .prog_hyst (prog_hyst),
        .thr       (thr)
    );

    rxfc_rts_ctrl rts_i (
        .clk         (clk),
        .rst         (rst),
        .level       (level),
        .thr         (thr),
        .auto_rts_en (auto_rts_en),
        .sw_rts      (sw_rts),
        .rts_irq_en  (rts_irq_en),
        .rts_irq_clr (rts_irq_clr),
        .rts_n       (rts_n),
        .rx_trig_irq (rx_trig_irq),
        .rts_irq     (rts_irq)
    );

    assign rd_data    = head.data;
    assign rd_brk     = head.brk;
    assign rd_frm     = head.frm;
    assign rd_par     = head.par;
    assign fill_level = level;

endmodule

// File: tb/rx_rts_flow_ctrl_tb.sv
`timescale 1ns/1ps
module rx_rts_flow_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, wr_brk, wr_frm, wr_par, rd_en;
    logic [7:0] wr_data, rd_data;
    logic       rd_brk, rd_frm, rd_par;
    logic [6:0] fill_level, prog_trig, prog_hyst;
    logic       tbl_mode;
    logic [1:0] tbl_sel;
    logic       auto_rts_en, rts_irq_en, sw_rts, rts_irq_clr;
    logic       rts_n, rx_trig_irq, rts_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    rx_rts_flow_ctrl dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par),
        .rd_en(rd_en), .rd_data(rd_data), .rd_brk(rd_brk), .rd_frm(rd_frm), .rd_par(rd_par),
        .fill_level(fill_level), .tbl_mode(tbl_mode), .tbl_sel(tbl_sel),
        .prog_trig(prog_trig), .prog_hyst(prog_hyst), .auto_rts_en(auto_rts_en),
        .rts_irq_en(rts_irq_en), .sw_rts(sw_rts), .rts_irq_clr(rts_irq_clr),
        .rts_n(rts_n), .rx_trig_irq(rx_trig_irq), .rts_irq(rts_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected-state model
    int  e_trig, e_up, e_lo;
    bit  e_paused, e_prev_rts_n, e_irq;

    function automatic int tbl_val(input int i);
        if (i < 0) return 0;
        if (i > 3) return 64;
        case (i)
            0: return 8;
            1: return 16;
            2: return 32;
            default: return 56;
        endcase
    endfunction

    function automatic void model_step(input int lvl);
        if (lvl >= e_up) e_paused = 1'b1;
        else if (lvl <= e_lo) e_paused = 1'b0;
        if (e_paused && !e_prev_rts_n) e_irq = 1'b1;
        e_prev_rts_n = e_paused;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 0; rd_en = 0; wr_data = '0; wr_brk = 0; wr_frm = 0; wr_par = 0;
        rts_irq_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_one(input logic [7:0] d, input logic [2:0] tg);
        @(negedge clk);
        wr_en = 1; wr_data = d; {wr_brk, wr_frm, wr_par} = tg;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] dval(input int i, input int cfg);
        return 8'((i * 7 + cfg * 13) & 255);
    endfunction

    task automatic run_cfg(input bit mode, input int sel, input int trig, input int hyst, input int cfg);
        int t;
        tbl_mode = mode; tbl_sel = 2'(sel);
        prog_trig = 7'(trig); prog_hyst = 7'(hyst);
        auto_rts_en = 1; sw_rts = 1; rts_irq_en = 1;
        if (mode) begin
            e_trig = tbl_val(sel); e_up = tbl_val(sel + 1); e_lo = tbl_val(sel - 1);
        end else begin
            t = (trig > 64) ? 64 : trig;
            e_trig = t;
            e_up = (t + hyst > 64) ? 64 : t + hyst;
            e_lo = (t - hyst < 0) ? 0 : t - hyst;
        end
        do_reset();
        e_paused = 0; e_prev_rts_n = 1; e_irq = 0;
        @(negedge clk);
        @(negedge clk);
        model_step(0);
        chk(mode ? "R8 rts at empty" : "R7 rts at empty", int'(rts_n), int'(e_paused));
        for (int i = 1; i <= 64; i++) begin
            push_one(dval(i, cfg), 3'(i));
            model_step(i);
            chk("R11 level after push", int'(fill_level), i);
            chk(mode ? "R8 rts fill" : "R6 rts fill", int'(rts_n), int'(e_paused));
            chk("R5 trig irq fill", int'(rx_trig_irq), (i >= e_trig) ? 1 : 0);
        end
        push_one(8'hEE, 3'b111);
        chk("R4 push when full", int'(fill_level), 64);
        chk("R9 irq after pause", int'(rts_irq), int'(e_irq));
        @(negedge clk); rts_irq_clr = 1;
        @(negedge clk); rts_irq_clr = 0;
        e_irq = 0;
        chk("R10 irq cleared", int'(rts_irq), 0);
        for (int i = 1; i <= 64; i++) begin
            chk("R3 head data", int'(rd_data), int'(dval(i, cfg)));
            chk("R3 head tags", int'({rd_brk, rd_frm, rd_par}), i % 8);
            pop_one();
            model_step(64 - i);
            chk("R3 level after pop", int'(fill_level), 64 - i);
            chk(mode ? "R8 rts drain" : "R7 rts drain", int'(rts_n), int'(e_paused));
            chk("R5 trig irq drain", int'(rx_trig_irq), ((64 - i) >= e_trig) ? 1 : 0);
        end
        pop_one();
        chk("R4 pop when empty", int'(fill_level), 0);
        chk("R9 irq no rise on drain", int'(rts_irq), int'(e_irq));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        tbl_mode = 0; tbl_sel = 0; prog_trig = 7'd16; prog_hyst = 7'd8;
        auto_rts_en = 0; rts_irq_en = 0; sw_rts = 0;
        do_reset();
        #1;
        chk("R1 rts_n", int'(rts_n), 1);
        chk("R1 level", int'(fill_level), 0);
        chk("R1 rts_irq", int'(rts_irq), 0);
        chk("R1 trig irq", int'(rx_trig_irq), 0);

        // Manual pin control and interrupt enable
        @(negedge clk); sw_rts = 1;
        @(negedge clk);
        chk("R2 manual assert", int'(rts_n), 0);
        sw_rts = 0;
        @(negedge clk);
        chk("R2 manual deassert", int'(rts_n), 1);
        chk("R9 no irq when disabled", int'(rts_irq), 0);
        auto_rts_en = 1; sw_rts = 0;
        @(negedge clk); @(negedge clk);
        chk("R2 auto without sw request", int'(rts_n), 1);
        auto_rts_en = 0; rts_irq_en = 1; sw_rts = 1;
        @(negedge clk);
        chk("R2 rts low again", int'(rts_n), 0);
        sw_rts = 0;
        @(negedge clk);
        chk("R9 irq on rise", int'(rts_irq), 1);
        sw_rts = 1;
        @(negedge clk);
        chk("R10 irq held", int'(rts_irq), 1);
        sw_rts = 0; rts_irq_clr = 1;
        @(negedge clk);
        rts_irq_clr = 0;
        chk("R10 set wins over clear", int'(rts_irq), 1);
        rts_irq_clr = 1;
        @(negedge clk);
        rts_irq_clr = 0;
        chk("R10 clear alone", int'(rts_irq), 0);

        // Programmable sweeps
        run_cfg(1'b0, 0, 16, 8, 0);
        run_cfg(1'b0, 0, 0, 0, 1);
        run_cfg(1'b0, 0, 60, 10, 2);
        run_cfg(1'b0, 0, 5, 20, 3);
        run_cfg(1'b0, 0, 100, 3, 4);
        run_cfg(1'b0, 0, 33, 1, 5);
        // Table sweeps
        for (int s = 0; s < 4; s++) run_cfg(1'b1, s, 0, 0, 6 + s);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule